// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block is a hardware breakpoint unit for debug. It watches two buses at once: a CPU-side bus and a shared internal bus that several masters drive. Each of its channels holds a break address, a break data value and an ignore mask for each of the two. It qualifies every observed cycle by which bus carried it, whether it was an instruction fetch or a data access, and whether it was a read or a write. A channel set to watch the internal bus also compares the identity of the issuing master.

When a channel matches, the unit sets sticky flags that record the channel and the bus. It starts a trigger pulse whose width software selects. It also raises a single break request for the downstream interrupt logic, unless that channel is in trigger-only mode. The flags are set whether or not anything downstream takes the request. Software programs the unit and clears flags through a simple register port with a combinational read.

Register map (word addresses): channel c occupies addresses 8*c+0 to 8*c+4 (break address, address ignore mask, break data, data ignore mask, cycle qualifier). The flag register is at 8*NUM_CH and the control register is at 8*NUM_CH+1. With the default parameters these are addresses 16 and 17.

Top module: `bkpt_unit`

## Requirements
- R1: A channel's address comparison passes when the bus address equals the break address on every bit that is 0 in the address ignore mask; bits set to 1 in that mask are never compared.
- R2: A channel's data comparison passes when the bus data equals the break data on every bit that is 0 in the data ignore mask; bits set to 1 in that mask are never compared.
- R3: The cycle qualifier register holds three 2-bit fields. Bits [1:0] select the bus (01 CPU bus, 10 internal bus, 11 either). Bits [3:2] select the access kind (01 fetch, 10 data, 11 either). Bits [5:4] select the direction (01 read, 10 write, 11 either). A channel whose fields are all nonzero matches only cycles that every field permits. A channel with any field equal to 00 never matches.
- R4: A match of channel c sets flag bit 2*c when it occurs on the CPU bus and flag bit 2*c+1 when it occurs on the internal bus. Flags are set whether or not the break request is taken.
- R5: Any match starts a pulse on trig_out one cycle later. Control bits [1:0] set the pulse width: 00, 01, 10 and 11 give 1, 2, 4 and 8 clock cycles. A match during an active pulse restarts the full width.
- R6: Setting qualifier bit 7 (trigger-only) on a channel still sets its flags and fires the pulse on a match, but that channel's flags do not assert brk_req.
- R7: Flags are sticky until software writes 1 to them in the flag register. A match and a clear of the same bit in the same cycle leave the bit set.
- R8: brk_req is high whenever any flag of a channel without trigger-only is set. Matches of both channels in one cycle give one request and set both channels' flags.
- R9: For an internal-bus match, qualifier bits [15:8] must equal the master identifier on the internal bus. Cycles from other masters are ignored.
- R10: A new qualifier value takes effect from the cycle after its write. A bus cycle in the same cycle as the write is judged by the old value.
- R11: After reset all registers and flags are 0, brk_req and trig_out are low, and no channel matches.
- R12: Each channel register and the control register read back the value last written, limited to its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cbus_valid | input | 1 | CPU bus cycle present |
| cbus_addr | input | ADDR_W | CPU bus address |
| cbus_data | input | DATA_W | CPU bus data |
| cbus_fetch | input | 1 | CPU bus cycle is an instruction fetch |
| cbus_write | input | 1 | CPU bus cycle is a write |
| ibus_valid | input | 1 | Internal bus cycle present |
| ibus_addr | input | ADDR_W | Internal bus address |
| ibus_data | input | DATA_W | Internal bus data |
| ibus_fetch | input | 1 | Internal bus cycle is an instruction fetch |
| ibus_write | input | 1 | Internal bus cycle is a write |
| ibus_master | input | max(MASTER_W,1) | Identifier of the internal bus master |
| brk_req | output | 1 | Combined break request |
| trig_out | output | 1 | Trigger pulse |

## Verification
The assertions assume that the bus inputs are stable and free of X around the clock edge. They also assume the valid strobes carry no meaning when low, so a cycle with both valid inputs low is taken to be idle and must produce no match. The bench drives every input at the falling edge, holds each bus cycle valid for exactly one clock, and returns all strobes to 0 between scenarios. Register writes last one clock. The only time a write and a bus cycle share a clock is in the two scenarios that test a same-cycle clear and the arming delay.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   localparam int REG_DW = 32;
   localparam int CH_SPAN_LG = 3;

   localparam logic [2:0] IDX_ADDR  = 3'd0;
   localparam logic [2:0] IDX_AIGN  = 3'd1;
   localparam logic [2:0] IDX_DATA  = 3'd2;
   localparam logic [2:0] IDX_DIGN  = 3'd3;
   localparam logic [2:0] IDX_QUAL  = 3'd4;
   localparam logic [2:0] IDX_FLAGS = 3'd0;
   localparam logic [2:0] IDX_CTRL  = 3'd1;

   typedef enum logic [1:0] {
      Q_OFF    = 2'b00,
      Q_FIRST  = 2'b01,
      Q_SECOND = 2'b10,
      Q_EITHER = 2'b11
   } qual_e;

   typedef struct packed {
      logic [15:0] rsvd;
      logic [7:0]  master;
      logic        trig_only;
      logic        spare;
      qual_e       dir;
      qual_e       kind;
      qual_e       bus;
   } qual_cfg_t;

   function automatic logic qual_pass(qual_e q, logic second);
      case (q)
         Q_FIRST:  return !second;
         Q_SECOND: return second;
         Q_EITHER: return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bkpt_chan.sv
module bkpt_chan
   import bkpt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int MASTER_W = 2,
   parameter int MW       = 2
) (
   input  logic [ADDR_W-1:0] brk_addr,
   input  logic [ADDR_W-1:0] addr_ign,
   input  logic [DATA_W-1:0] brk_data,
   input  logic [DATA_W-1:0] data_ign,
   input  qual_cfg_t         cfg,
   input  logic              c_valid,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_data,
   input  logic              c_fetch,
   input  logic              c_write,
   input  logic              i_valid,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [DATA_W-1:0] i_data,
   input  logic              i_fetch,
   input  logic              i_write,
   input  logic [MW-1:0]     i_master,
   output logic              hit_cpu,
   output logic              hit_int
);

   logic cfg_live;
   logic master_ok;
   logic c_value_ok, i_value_ok;
   logic c_kind_ok, i_kind_ok;
   logic unused_cfg;

   function automatic logic value_eq(
      input logic [ADDR_W-1:0] a,
      input logic [DATA_W-1:0] d,
      input logic [ADDR_W-1:0] ba,
      input logic [ADDR_W-1:0] am,
      input logic [DATA_W-1:0] bd,
      input logic [DATA_W-1:0] dm
   );
      return (((a ^ ba) & ~am) == '0) && (((d ^ bd) & ~dm) == '0);
   endfunction

   generate
      if (MASTER_W > 0) begin : g_master_cmp
         assign master_ok = (i_master == cfg.master[MW-1:0]);
         if (MW < 8) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^cfg.master[7:MW];
         end
      end else begin : g_master_any
         logic unused_id;
         assign unused_id = ^{i_master, cfg.master};
         assign master_ok = 1'b1;
      end
   endgenerate

   assign unused_cfg = ^{cfg.rsvd, cfg.spare, cfg.trig_only};

   assign cfg_live   = (cfg.bus != Q_OFF) && (cfg.kind != Q_OFF) && (cfg.dir != Q_OFF);
   assign c_value_ok = value_eq(c_addr, c_data, brk_addr, addr_ign, brk_data, data_ign);
   assign i_value_ok = value_eq(i_addr, i_data, brk_addr, addr_ign, brk_data, data_ign);
   assign c_kind_ok  = qual_pass(cfg.kind, !c_fetch) && qual_pass(cfg.dir, c_write);
   assign i_kind_ok  = qual_pass(cfg.kind, !i_fetch) && qual_pass(cfg.dir, i_write);

   assign hit_cpu = cfg_live && c_valid && qual_pass(cfg.bus, 1'b0)
                    && c_kind_ok && c_value_ok;
   assign hit_int = cfg_live && i_valid && qual_pass(cfg.bus, 1'b1)
                    && i_kind_ok && i_value_ok && master_ok;

endmodule

// File: rtl/bkpt_pulse.sv
module bkpt_pulse #(
   parameter int WSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [WSEL_W-1:0] wsel,
   output logic              pulse
);

   localparam int CNT_W = (1 << WSEL_W) - 1;

   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] remain_q;
   logic             active_q;

   assign span     = (CNT_W+1)'(1) << wsel;
   assign load_val = CNT_W'(span - (CNT_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         remain_q <= '0;
      end else if (fire) begin
         active_q <= 1'b1;
         remain_q <= load_val;
      end else if (active_q) begin
         if (remain_q == '0) begin
            active_q <= 1'b0;
         end else begin
            remain_q <= remain_q - CNT_W'(1);
         end
      end
   end

   assign pulse = active_q;

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
   import bkpt_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_AW = 5,
   parameter int FLAG_W = 2 * NUM_CH
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [REG_AW-1:0]             addr,
   input  logic [REG_DW-1:0]             wdata,
   output logic [REG_DW-1:0]             rdata,
   input  logic [FLAG_W-1:0]             flag_set,
   output logic [NUM_CH-1:0][ADDR_W-1:0] ba_o,
   output logic [NUM_CH-1:0][ADDR_W-1:0] aign_o,
   output logic [NUM_CH-1:0][DATA_W-1:0] bd_o,
   output logic [NUM_CH-1:0][DATA_W-1:0] dign_o,
   output qual_cfg_t [NUM_CH-1:0]        cfg_o,
   output logic [FLAG_W-1:0]             flags_o,
   output logic [FLAG_W-1:0]             clr_o,
   output logic [1:0]                    wsel_o
);

   localparam int SEL_W = REG_AW - CH_SPAN_LG;
   localparam logic [SEL_W-1:0] GLB_SEL = SEL_W'(NUM_CH);

   logic [SEL_W-1:0] sel;
   logic [2:0]       idx;
   logic             glb_hit;
   logic [FLAG_W-1:0] flags_q;
   logic [1:0]        wsel_q;

   assign sel     = addr[REG_AW-1:CH_SPAN_LG];
   assign idx     = addr[CH_SPAN_LG-1:0];
   assign glb_hit = (sel == GLB_SEL);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(c);
         logic wr_me;
         assign wr_me = wr && (sel == MY_SEL);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ba_o[c]   <= '0;
               aign_o[c] <= '0;
               bd_o[c]   <= '0;
               dign_o[c] <= '0;
               cfg_o[c]  <= '0;
            end else if (wr_me) begin
               case (idx)
                  IDX_ADDR: ba_o[c]   <= wdata[ADDR_W-1:0];
                  IDX_AIGN: aign_o[c] <= wdata[ADDR_W-1:0];
                  IDX_DATA: bd_o[c]   <= wdata[DATA_W-1:0];
                  IDX_DIGN: dign_o[c] <= wdata[DATA_W-1:0];
                  IDX_QUAL: cfg_o[c]  <= qual_cfg_t'(wdata);
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   assign clr_o = (wr && glb_hit && idx == IDX_FLAGS) ? wdata[FLAG_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         wsel_q  <= '0;
      end else begin
         flags_q <= (flags_q & ~clr_o) | flag_set;
         if (wr && glb_hit && idx == IDX_CTRL) begin
            wsel_q <= wdata[1:0];
         end
      end
   end

   assign flags_o = flags_q;
   assign wsel_o  = wsel_q;

   always_comb begin
      rdata = '0;
      if (glb_hit) begin
         case (idx)
            IDX_FLAGS: rdata = REG_DW'(flags_q);
            IDX_CTRL:  rdata = REG_DW'(wsel_q);
            default:   rdata = '0;
         endcase
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (sel == SEL_W'(c)) begin
               case (idx)
                  IDX_ADDR: rdata = REG_DW'(ba_o[c]);
                  IDX_AIGN: rdata = REG_DW'(aign_o[c]);
                  IDX_DATA: rdata = REG_DW'(bd_o[c]);
                  IDX_DIGN: rdata = REG_DW'(dign_o[c]);
                  IDX_QUAL: rdata = cfg_o[c];
                  default:  rdata = '0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
   import bkpt_pkg::*;
#(
   parameter  int NUM_CH   = 2,
   parameter  int ADDR_W   = 32,
   parameter  int DATA_W   = 32,
   parameter  int MASTER_W = 2,
   parameter  int REG_AW   = 5,
   localparam int MW       = (MASTER_W > 0) ? MASTER_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cbus_valid,
   input  logic [ADDR_W-1:0] cbus_addr,
   input  logic [DATA_W-1:0] cbus_data,
   input  logic              cbus_fetch,
   input  logic              cbus_write,
   input  logic              ibus_valid,
   input  logic [ADDR_W-1:0] ibus_addr,
   input  logic [DATA_W-1:0] ibus_data,
   input  logic              ibus_fetch,
   input  logic              ibus_write,
   input  logic [MW-1:0]     ibus_master,
   output logic              brk_req,
   output logic              trig_out
);

   localparam int FLAG_W = 2 * NUM_CH;

   generate
      if (NUM_CH < 1 || FLAG_W > REG_DW) begin : g_bad_ch
         $error("bkpt_unit: NUM_CH out of range");
      end
      if (ADDR_W < 1 || ADDR_W > REG_DW || DATA_W < 1 || DATA_W > REG_DW) begin : g_bad_w
         $error("bkpt_unit: bus width out of range");
      end
      if (MASTER_W < 0 || MASTER_W > 8) begin : g_bad_m
         $error("bkpt_unit: MASTER_W out of range");
      end
      if ((NUM_CH + 1) * (1 << CH_SPAN_LG) > (1 << REG_AW)) begin : g_bad_map
         $error("bkpt_unit: REG_AW too small for register map");
      end
   endgenerate

   logic [NUM_CH-1:0][ADDR_W-1:0] ba, aign;
   logic [NUM_CH-1:0][DATA_W-1:0] bd, dign;
   qual_cfg_t [NUM_CH-1:0]        cfg;
   logic [FLAG_W-1:0]             hit_set;
   logic [FLAG_W-1:0]             flag_q;
   logic [FLAG_W-1:0]             flag_clr;
   logic [1:0]                    wsel;
   logic [NUM_CH-1:0]             ch_flag;
   logic [NUM_CH-1:0]             req_en;

   bkpt_regs #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_AW (REG_AW),
      .FLAG_W (FLAG_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .flag_set (hit_set),
      .ba_o     (ba),
      .aign_o   (aign),
      .bd_o     (bd),
      .dign_o   (dign),
      .cfg_o    (cfg),
      .flags_o  (flag_q),
      .clr_o    (flag_clr),
      .wsel_o   (wsel)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         bkpt_chan #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .MASTER_W (MASTER_W),
            .MW       (MW)
         ) u_chan (
            .brk_addr (ba[c]),
            .addr_ign (aign[c]),
            .brk_data (bd[c]),
            .data_ign (dign[c]),
            .cfg      (cfg[c]),
            .c_valid  (cbus_valid),
            .c_addr   (cbus_addr),
            .c_data   (cbus_data),
            .c_fetch  (cbus_fetch),
            .c_write  (cbus_write),
            .i_valid  (ibus_valid),
            .i_addr   (ibus_addr),
            .i_data   (ibus_data),
            .i_fetch  (ibus_fetch),
            .i_write  (ibus_write),
            .i_master (ibus_master),
            .hit_cpu  (hit_set[2*c]),
            .hit_int  (hit_set[2*c+1])
         );
         assign ch_flag[c] = flag_q[2*c] | flag_q[2*c+1];
         assign req_en[c]  = !cfg[c].trig_only;
      end
   endgenerate

   assign brk_req = |(ch_flag & req_en);

   bkpt_pulse #(
      .WSEL_W (2)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (|hit_set),
      .wsel  (wsel),
      .pulse (trig_out)
   );

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
   parameter int NUM_CH = 2,
   parameter int FLAG_W = 2 * NUM_CH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cbus_valid,
   input logic              ibus_valid,
   input logic [FLAG_W-1:0] hit_vec,
   input logic [FLAG_W-1:0] flags,
   input logic [FLAG_W-1:0] clr_mask,
   input logic              brk_req,
   input logic              trig_out
);

   logic [3:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (|hit_vec) begin
         run_len <= '0;
      end else if (trig_out && run_len != 4'hF) begin
         run_len <= run_len + 4'd1;
      end
   end

   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cbus_valid && !ibus_valid) |-> (hit_vec == '0)); // R4

   AST_HIT_FIRES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> trig_out); // R5

   AST_TRIG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_out) |-> $past(|hit_vec)); // R5

   AST_TRIG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (run_len < 4'd8)); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask))); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> ((flags & $past(hit_vec)) == $past(hit_vec))); // R7

   AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> (flags != '0)); // R8

endmodule

bind bkpt_unit bkpt_unit_chk #(
   .NUM_CH (NUM_CH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cbus_valid (cbus_valid),
   .ibus_valid (ibus_valid),
   .hit_vec    (hit_set),
   .flags      (flag_q),
   .clr_mask   (flag_clr),
   .brk_req    (brk_req),
   .trig_out   (trig_out)
);

// File: tb/bkpt_unit_bench.sv
`timescale 1ns/1ps
module bkpt_unit_bench;

   localparam int AW = 5;
   localparam logic [AW-1:0] A_FLAGS = 5'd16;
   localparam logic [AW-1:0] A_CTRL  = 5'd17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cbus_valid = 1'b0, cbus_fetch = 1'b0, cbus_write = 1'b0;
   logic [31:0] cbus_addr = '0, cbus_data = '0;
   logic        ibus_valid = 1'b0, ibus_fetch = 1'b0, ibus_write = 1'b0;
   logic [31:0] ibus_addr = '0, ibus_data = '0;
   logic [1:0]  ibus_master = '0;
   logic        brk_req, trig_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   bkpt_unit u_bkpt_unit (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cbus_valid(cbus_valid), .cbus_addr(cbus_addr), .cbus_data(cbus_data),
      .cbus_fetch(cbus_fetch), .cbus_write(cbus_write),
      .ibus_valid(ibus_valid), .ibus_addr(ibus_addr), .ibus_data(ibus_data),
      .ibus_fetch(ibus_fetch), .ibus_write(ibus_write), .ibus_master(ibus_master),
      .brk_req(brk_req), .trig_out(trig_out)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] qual(int bus, int kind, int dir, int tonly, int mst);
      return 32'(bus) | (32'(kind) << 2) | (32'(dir) << 4) | (32'(tonly) << 7) | (32'(mst) << 8);
   endfunction

   task automatic wr_reg(logic [AW-1:0] a, logic [31:0] v);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [AW-1:0] a, output logic [31:0] v);
      reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic set_bus(bit ib, logic [31:0] a, logic [31:0] d, bit f, bit w, logic [1:0] m);
      if (ib) begin
         ibus_valid = 1'b1; ibus_addr = a; ibus_data = d; ibus_fetch = f; ibus_write = w; ibus_master = m;
      end else begin
         cbus_valid = 1'b1; cbus_addr = a; cbus_data = d; cbus_fetch = f; cbus_write = w;
      end
   endtask

   task automatic idle_bus();
      cbus_valid = 1'b0; ibus_valid = 1'b0;
   endtask

   task automatic bus_cycle(bit ib, logic [31:0] a, logic [31:0] d, bit f, bit w, logic [1:0] m);
      set_bus(ib, a, d, f, w, m);
      @(posedge clk); @(negedge clk);
      idle_bus();
   endtask

   task automatic flush();
      wr_reg(A_FLAGS, 32'hF);
      repeat (10) @(negedge clk);
   endtask

   task automatic setup_ch(int c, logic [31:0] ba, logic [31:0] am, logic [31:0] bd,
                           logic [31:0] dm, logic [31:0] q);
      wr_reg(AW'(8*c + 0), ba);
      wr_reg(AW'(8*c + 1), am);
      wr_reg(AW'(8*c + 2), bd);
      wr_reg(AW'(8*c + 3), dm);
      wr_reg(AW'(8*c + 4), q);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R11 brk_req after reset", 32'(brk_req), 0);
      chk("R11 trig_out after reset", 32'(trig_out), 0);
      rd_reg(A_FLAGS, v); chk("R11 flags after reset", v, 0);
      rd_reg(5'd4, v);    chk("R11 qualifier after reset", v, 0);
      bus_cycle(0, 32'h0, 32'h0, 0, 0, 0);
      rd_reg(A_FLAGS, v); chk("R11 no match when unprogrammed", v, 0);
   endtask

   task automatic t_readback();
      logic [31:0] v;
      wr_reg(5'd8, 32'hCAFE_0123); rd_reg(5'd8, v); chk("R12 ch1 address readback", v, 32'hCAFE_0123);
      wr_reg(A_CTRL, 32'hFFFF_FFFE); rd_reg(A_CTRL, v); chk("R12 ctrl readback width", v, 32'h2);
      wr_reg(A_CTRL, 32'h0);
   endtask

   task automatic t_exact();
      logic [31:0] v;
      setup_ch(0, 32'h1000_0040, 0, 32'h5A5A_0001, 0, qual(1, 2, 1, 0, 0));
      bus_cycle(0, 32'h1000_0040, 32'h5A5A_0001, 0, 0, 0);
      chk("R8 request after match", 32'(brk_req), 1);
      chk("R5 pulse after match", 32'(trig_out), 1);
      rd_reg(A_FLAGS, v); chk("R4 cpu flag of ch0", v, 32'h1);
      flush();
   endtask

   task automatic t_masks();
      logic [31:0] v;
      setup_ch(0, 32'h2000_0000, 32'h0000_00FF, 32'hAAAA_0000, 32'h0000_FFFF, qual(1, 3, 3, 0, 0));
      bus_cycle(0, 32'h2000_0037, 32'hAAAA_1234, 0, 1, 0);
      rd_reg(A_FLAGS, v); chk("R1 ignored address bits", v, 32'h1);
      flush();
      bus_cycle(0, 32'h2000_0137, 32'hAAAA_1234, 0, 1, 0);
      rd_reg(A_FLAGS, v); chk("R1 compared address bit differs", v, 32'h0);
      bus_cycle(0, 32'h2000_0000, 32'hAAAB_0000, 0, 1, 0);
      rd_reg(A_FLAGS, v); chk("R2 compared data bit differs", v, 32'h0);
      bus_cycle(0, 32'h2000_0000, 32'hAAAA_FFFF, 1, 0, 0);
      rd_reg(A_FLAGS, v); chk("R2 ignored data bits", v, 32'h1);
      flush();
   endtask

   task automatic t_qualifiers();
      logic [31:0] v;
      setup_ch(0, 32'h3000_0000, 0, 0, 32'hFFFF_FFFF, qual(1, 1, 0, 0, 0));
      bus_cycle(0, 32'h3000_0000, 0, 1, 0, 0);
      bus_cycle(0, 32'h3000_0000, 0, 1, 1, 0);
      rd_reg(A_FLAGS, v); chk("R3 direction field 00 disables", v, 0);
      wr_reg(5'd4, qual(1, 1, 1, 0, 0));
      bus_cycle(0, 32'h3000_0000, 0, 1, 1, 0);
      rd_reg(A_FLAGS, v); chk("R3 write rejected by read-only", v, 0);
      bus_cycle(0, 32'h3000_0000, 0, 0, 0, 0);
      rd_reg(A_FLAGS, v); chk("R3 data access rejected by fetch-only", v, 0);
      bus_cycle(0, 32'h3000_0000, 0, 1, 0, 0);
      rd_reg(A_FLAGS, v); chk("R3 fetch read accepted", v, 32'h1);
      flush();
      wr_reg(5'd4, 0);
   endtask

   task automatic t_width();
      for (int s = 0; s < 4; s++) begin
         int n;
         setup_ch(0, 32'h4000_0000, 0, 0, 32'hFFFF_FFFF, qual(1, 3, 3, 0, 0));
         wr_reg(A_CTRL, 32'(s));
         bus_cycle(0, 32'h4000_0000, 0, 0, 0, 0);
         n = 0;
         while (trig_out && n < 20) begin n++; @(negedge clk); end
         chk($sformatf("R5 pulse width sel %0d", s), 32'(n), 32'(1 << s));
         flush();
      end
   endtask

   task automatic t_restart();
      int n;
      wr_reg(A_CTRL, 32'h2);
      bus_cycle(0, 32'h4000_0000, 0, 0, 0, 0);
      bus_cycle(0, 32'h4000_0000, 0, 0, 0, 0);
      n = 0;
      while (trig_out && n < 20) begin n++; @(negedge clk); end
      chk("R5 restart gives full width", 32'(n), 4);
      wr_reg(A_CTRL, 0);
      flush();
   endtask

   task automatic t_trig_only();
      logic [31:0] v;
      setup_ch(0, 32'h5000_0000, 0, 0, 32'hFFFF_FFFF, qual(1, 3, 3, 1, 0));
      bus_cycle(0, 32'h5000_0000, 0, 0, 0, 0);
      chk("R6 no request in trigger-only", 32'(brk_req), 0);
      chk("R6 pulse in trigger-only", 32'(trig_out), 1);
      rd_reg(A_FLAGS, v); chk("R6 flag in trigger-only", v, 32'h1);
      wr_reg(5'd4, qual(1, 3, 3, 0, 0));
      chk("R8 request follows pending flag", 32'(brk_req), 1);
      flush();
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      bus_cycle(0, 32'h5000_0000, 0, 0, 0, 0);
      repeat (12) @(negedge clk);
      rd_reg(A_FLAGS, v); chk("R7 flag sticky", v, 32'h1);
      chk("R7 request held by flag", 32'(brk_req), 1);
      reg_wr = 1'b1; reg_addr = A_FLAGS; reg_wdata = 32'h1;
      set_bus(0, 32'h5000_0000, 0, 0, 0, 0);
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0; idle_bus();
      rd_reg(A_FLAGS, v); chk("R7 match beats clear", v, 32'h1);
      wr_reg(A_FLAGS, 32'h1);
      rd_reg(A_FLAGS, v); chk("R7 write one clears", v, 0);
      chk("R8 request drops after clear", 32'(brk_req), 0);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_both();
      logic [31:0] v;
      setup_ch(1, 32'h5000_0000, 0, 0, 32'hFFFF_FFFF, qual(1, 3, 3, 0, 0));
      bus_cycle(0, 32'h5000_0000, 0, 0, 0, 0);
      rd_reg(A_FLAGS, v); chk("R8 both channel flags", v, 32'h5);
      chk("R8 single request", 32'(brk_req), 1);
      flush();
      wr_reg(5'd4, 0); wr_reg(5'd12, 0);
   endtask

   task automatic t_master();
      logic [31:0] v;
      setup_ch(1, 32'h6000_0000, 0, 0, 32'hFFFF_FFFF, qual(2, 3, 3, 0, 2));
      bus_cycle(1, 32'h6000_0000, 0, 0, 1, 2'd1);
      rd_reg(A_FLAGS, v); chk("R9 other master ignored", v, 0);
      bus_cycle(0, 32'h6000_0000, 0, 0, 1, 2'd2);
      rd_reg(A_FLAGS, v); chk("R3 cpu bus rejected by internal select", v, 0);
      bus_cycle(1, 32'h6000_0000, 0, 0, 1, 2'd2);
      rd_reg(A_FLAGS, v); chk("R9 selected master matches", v, 32'h8);
      flush();
      wr_reg(5'd12, 0);
   endtask

   task automatic t_arm();
      logic [31:0] v;
      wr_reg(5'd0, 32'h7000_0000); wr_reg(5'd3, 32'hFFFF_FFFF);
      reg_wr = 1'b1; reg_addr = 5'd4; reg_wdata = qual(1, 3, 3, 0, 0);
      set_bus(0, 32'h7000_0000, 0, 0, 0, 0);
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      rd_reg(A_FLAGS, v); chk("R10 no match in write cycle", v, 0);
      @(posedge clk); @(negedge clk);
      idle_bus();
      rd_reg(A_FLAGS, v); chk("R10 match in following cycle", v, 32'h1);
      flush();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_exact();
      t_masks();
      t_qualifiers();
      t_width();
      t_restart();
      t_trig_only();
      t_sticky();
      t_both();
      t_master();
      t_arm();
      finish_run();
   end

endmodule